// File: doc/BRIEF.md
# Split-Write Port Command Decoder

This block takes a 32-bit port command that a 16-bit host delivers as two halfword writes and turns it into one of four actions. The host first writes the lower half to the base port location and then the upper half to base+2. Only the upper write makes the command take effect. The assembled word's bits 3:0 select the action, and bits 31:4 carry a 16-byte-aligned memory address.

The four actions are as follows. A reset command holds the block busy until both a system-clock count and a transmit-clock count have elapsed. A self-test command emits a two-word result record. A set-pointer command latches a new configuration-pointer address. A dump command emits a two-word snapshot of internal state.

The block does not perform memory transfers. Result records appear on a valid/data output, one word per cycle. Each decoded action also produces a one-cycle pulse.

Top module: `portCmdDecoder`

## Requirements
- R1: A write with `wrHigh`=0 stores the lower half. A following write with `wrHigh`=1 supplies the upper half, and the command word is {upper, lower}. The command acts only on the upper write.
- R2: Code 0 is reset, 1 is self-test, 2 is set-pointer and 3 is dump. Each accepted code raises its own pulse for exactly one cycle, in the cycle after the clock edge that takes the upper write.
- R3: An upper write with no pending lower half is ignored. An executed command consumes the pending lower half.
- R4: A second lower write before the upper write replaces the pending lower half.
- R5: Set-pointer loads `ptrAddr` with word bits 31:4 and with bits 3:0 set to zero. `ptrAddr` changes on no other event.
- R6: After a reset command, `busy` stays high for at least SYS_WAIT (5) system clocks and until at least TX_WAIT (10) `txClk` rising edges have passed. While `busy` is high, writes of either half are ignored. A reset command leaves `ptrAddr` unchanged.
- R7: Self-test drives `resultValid` for two consecutive cycles, starting in the same cycle as its pulse. The first word is the SIGNATURE parameter. The second word, captured at the command, has these bits: bit 12 when any fault is set, bit 5 from `testFaults[3]` (diagnose), bit 4 from `testFaults[2]` (bus timer), bit 3 from `testFaults[1]` (register), and bit 2 from `testFaults[0]` (ROM). All other bits are 0.
- R8: Dump drives `resultValid` for two consecutive cycles, starting in the same cycle as its pulse. The first word is `ptrAddr` as it was before the dump. The second word is the full command word that requested the dump. `busy` is high during both result cycles.
- R9: Codes 4 to 15 raise no pulse, produce no result and leave `ptrAddr` unchanged. They still consume the pending lower half.
- R10: After reset, all pulses, `busy` and `resultValid` are 0, and `ptrAddr` and `resultData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| txClk | input | 1 | Transmit clock used for the reset hold-off count |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Host write strobe |
| wrHigh | input | 1 | Halfword select: 0 = base (lower half), 1 = base+2 (upper half) |
| wrData | input | 16 | Host write data |
| testFaults | input | 4 | Self-test fault flags: [3] diagnose, [2] bus timer, [1] register, [0] ROM |
| resetPulse | output | 1 | One-cycle pulse for a reset command |
| selfTestPulse | output | 1 | One-cycle pulse for a self-test command |
| setPtrPulse | output | 1 | One-cycle pulse for a set-pointer command |
| dumpPulse | output | 1 | One-cycle pulse for a dump command |
| ptrAddr | output | 32 | Latched configuration-pointer address |
| busy | output | 1 | High during reset hold-off and while a result is emitted |
| resultValid | output | 1 | Result word valid |
| resultData | output | 32 | Result word (0 when not valid) |

## Verification
The embedded assertions check the following on every cycle:
- At most one command pulse is high at a time.
- `ptrAddr` never moves without a set-pointer pulse.
- A lone lower write never yields a pulse.
- A reset holds `busy` for its minimum system-clock window.
- `busy` is not released while the transmit-domain completion is still outstanding.

Only the bench scenarios can show the rest:
- Correct word assembly across the two halves, and the ignored orphan upper write.
- Overwriting of the pending lower half.
- The exact result-word contents for various fault patterns.
- The hold-off length under both a slow and a fast transmit clock.

// File: rtl/portCmdPkg.sv
`timescale 1ns/1ps
package portCmdPkg;
  localparam int HalfW = 16;
  localparam int WordW = 2 * HalfW;
  localparam int OpW   = 4;

  localparam logic [OpW-1:0] OpReset    = 4'd0;
  localparam logic [OpW-1:0] OpSelfTest = 4'd1;
  localparam logic [OpW-1:0] OpSetPtr   = 4'd2;
  localparam logic [OpW-1:0] OpDump     = 4'd3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SIG, SEL_STAT, SEL_PTR, SEL_CMD
  } resultSel_e;

  typedef struct packed {
    logic       takeLow;
    logic       fire;
    logic       loadPtr;
    resultSel_e resultSel;
  } dpStrobes_t;
endpackage

// File: rtl/portCmdTxHoldoff.sv
`timescale 1ns/1ps
module portCmdTxHoldoff #(
  parameter int TX_WAIT = 10
) (
  input  logic txClk,
  input  logic rstN,
  input  logic reqToggle,
  output logic doneToggle
);
  localparam int CntW = $clog2(TX_WAIT + 1);

  logic reqSync1, reqSync2, reqSeen;
  logic [CntW-1:0] txCnt;

  always_ff @(posedge txClk or negedge rstN) begin
    if (!rstN) begin
      reqSync1   <= 1'b0;
      reqSync2   <= 1'b0;
      reqSeen    <= 1'b0;
      txCnt      <= '0;
      doneToggle <= 1'b0;
    end else begin
      reqSync1 <= reqToggle;
      reqSync2 <= reqSync1;
      if (reqSync2 != reqSeen) begin
        reqSeen <= reqSync2;
        txCnt   <= CntW'(TX_WAIT);
      end else if (txCnt == CntW'(1)) begin
        txCnt      <= '0;
        doneToggle <= ~doneToggle;
      end else if (txCnt != '0) begin
        txCnt <= txCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/portCmdDatapath.sv
`timescale 1ns/1ps
module portCmdDatapath
  import portCmdPkg::*;
#(
  parameter logic [31:0] SIGNATURE = 32'hC0DE_5A17
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic [HalfW-1:0]   wrData,
  input  logic [3:0]         testFaults,
  output logic               lowPending,
  output logic [OpW-1:0]     opCode,
  output logic [WordW-1:0]   ptrAddr,
  output logic [WordW-1:0]   resultData
);
  logic [HalfW-1:0] lowHalf;
  logic [WordW-1:0] cmdWord;
  logic [3:0]       faultHold;
  logic [WordW-1:0] statusWord;

  assign opCode = lowHalf[OpW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowHalf    <= '0;
      lowPending <= 1'b0;
      cmdWord    <= '0;
      faultHold  <= '0;
      ptrAddr    <= '0;
    end else begin
      if (strobes.takeLow) begin
        lowHalf    <= wrData;
        lowPending <= 1'b1;
      end
      if (strobes.fire) begin
        lowPending <= 1'b0;
        cmdWord    <= {wrData, lowHalf};
        faultHold  <= testFaults;
      end
      if (strobes.loadPtr)
        ptrAddr <= {wrData, lowHalf[HalfW-1:OpW], {OpW{1'b0}}};
    end
  end

  always_comb begin
    statusWord     = '0;
    statusWord[12] = |faultHold;
    statusWord[5]  = faultHold[3];
    statusWord[4]  = faultHold[2];
    statusWord[3]  = faultHold[1];
    statusWord[2]  = faultHold[0];
  end

  always_comb begin
    unique case (strobes.resultSel)
      SEL_SIG:  resultData = SIGNATURE;
      SEL_STAT: resultData = statusWord;
      SEL_PTR:  resultData = ptrAddr;
      SEL_CMD:  resultData = cmdWord;
      default:  resultData = '0;
    endcase
  end

  // R5
  ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPtr |=> (ptrAddr[OpW-1:0] == '0) && !lowPending);
endmodule

// File: rtl/portCmdControl.sv
`timescale 1ns/1ps
module portCmdControl
  import portCmdPkg::*;
#(
  parameter int SYS_WAIT = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic           wrHigh,
  input  logic           lowPending,
  input  logic [OpW-1:0] opCode,
  input  logic           txDoneToggle,
  output dpStrobes_t     strobes,
  output logic           txReqToggle,
  output logic           resetPulse,
  output logic           selfTestPulse,
  output logic           setPtrPulse,
  output logic           dumpPulse,
  output logic           busy,
  output logic           resultValid
);
  localparam int CntW = $clog2(SYS_WAIT) + 1;
  localparam logic [CntW-1:0] HoldLast = CntW'(SYS_WAIT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_EMIT0, ST_EMIT1} ctrlState_e;
  ctrlState_e state;

  logic [CntW-1:0] holdCnt;
  logic doneSync1, doneSync2, doneSeen, txDone, kindDump;
  logic accept, fire;

  assign accept = wrEn && (state == ST_IDLE);
  assign fire   = accept && wrHigh && lowPending;
  assign busy   = (state != ST_IDLE);
  assign resultValid = (state == ST_EMIT0) || (state == ST_EMIT1);

  always_comb begin
    strobes.takeLow = accept && !wrHigh;
    strobes.fire    = fire;
    strobes.loadPtr = fire && (opCode == OpSetPtr);
    unique case (state)
      ST_EMIT0: strobes.resultSel = kindDump ? SEL_PTR : SEL_SIG;
      ST_EMIT1: strobes.resultSel = kindDump ? SEL_CMD : SEL_STAT;
      default:  strobes.resultSel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      holdCnt       <= '0;
      doneSync1     <= 1'b0;
      doneSync2     <= 1'b0;
      doneSeen      <= 1'b0;
      txDone        <= 1'b0;
      kindDump      <= 1'b0;
      txReqToggle   <= 1'b0;
      resetPulse    <= 1'b0;
      selfTestPulse <= 1'b0;
      setPtrPulse   <= 1'b0;
      dumpPulse     <= 1'b0;
    end else begin
      doneSync1 <= txDoneToggle;
      doneSync2 <= doneSync1;
      if (doneSync2 != doneSeen) begin
        doneSeen <= doneSync2;
        txDone   <= 1'b1;
      end
      resetPulse    <= fire && (opCode == OpReset);
      selfTestPulse <= fire && (opCode == OpSelfTest);
      setPtrPulse   <= fire && (opCode == OpSetPtr);
      dumpPulse     <= fire && (opCode == OpDump);
      unique case (state)
        ST_IDLE: if (fire) begin
          if (opCode == OpReset) begin
            state       <= ST_HOLD;
            holdCnt     <= '0;
            txDone      <= 1'b0;
            txReqToggle <= ~txReqToggle;
          end else if (opCode == OpSelfTest || opCode == OpDump) begin
            state    <= ST_EMIT0;
            kindDump <= (opCode == OpDump);
          end
        end
        ST_HOLD: begin
          if (holdCnt != HoldLast) holdCnt <= holdCnt + 1'b1;
          else if (txDone) state <= ST_IDLE;
        end
        ST_EMIT0: state <= ST_EMIT1;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R6
  reset_hold_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> busy ##1 busy ##1 busy ##1 busy ##1 busy);

  // R6
  hold_until_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !txDone) |=> busy);

  // R8
  result_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> (selfTestPulse || dumpPulse));
endmodule

// File: rtl/portCmdDecoder.sv
`timescale 1ns/1ps
module portCmdDecoder
  import portCmdPkg::*;
#(
  parameter logic [31:0] SIGNATURE = 32'hC0DE_5A17,
  parameter int          SYS_WAIT  = 5,
  parameter int          TX_WAIT   = 10
) (
  input  logic        clk,
  input  logic        txClk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrHigh,
  input  logic [15:0] wrData,
  input  logic [3:0]  testFaults,
  output logic        resetPulse,
  output logic        selfTestPulse,
  output logic        setPtrPulse,
  output logic        dumpPulse,
  output logic [31:0] ptrAddr,
  output logic        busy,
  output logic        resultValid,
  output logic [31:0] resultData
);
  dpStrobes_t     strobes;
  logic           lowPending;
  logic [OpW-1:0] opCode;
  logic           txReqToggle, txDoneToggle;

  portCmdControl #(.SYS_WAIT(SYS_WAIT)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrHigh(wrHigh),
    .lowPending(lowPending), .opCode(opCode), .txDoneToggle(txDoneToggle),
    .strobes(strobes), .txReqToggle(txReqToggle),
    .resetPulse(resetPulse), .selfTestPulse(selfTestPulse),
    .setPtrPulse(setPtrPulse), .dumpPulse(dumpPulse),
    .busy(busy), .resultValid(resultValid)
  );

  portCmdDatapath #(.SIGNATURE(SIGNATURE)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .testFaults(testFaults), .lowPending(lowPending), .opCode(opCode),
    .ptrAddr(ptrAddr), .resultData(resultData)
  );

  portCmdTxHoldoff #(.TX_WAIT(TX_WAIT)) txHold (
    .txClk(txClk), .rstN(rstN), .reqToggle(txReqToggle),
    .doneToggle(txDoneToggle)
  );

  // R2
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetPulse, selfTestPulse, setPtrPulse, dumpPulse}));

  // R5
  ptr_only_on_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptrAddr != $past(ptrAddr)) |-> setPtrPulse);

  // R1
  low_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrHigh) |=>
      !(resetPulse || selfTestPulse || setPtrPulse || dumpPulse));
endmodule

// File: tb/tb_portCmdDecoder.sv
`timescale 1ns/1ps
module tb_portCmdDecoder;
  localparam logic [31:0] SIG = 32'hC0DE_5A17;

  logic clk = 1'b0, txClk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, wrHigh = 1'b0;
  logic [15:0] wrData = '0;
  logic [3:0]  testFaults = '0;
  logic resetPulse, selfTestPulse, setPtrPulse, dumpPulse, busy, resultValid;
  logic [31:0] ptrAddr, resultData;

  int checks = 0, fails = 0;
  int txHalf = 3;
  int txEdges = 0;

  portCmdDecoder dut (
    .clk(clk), .txClk(txClk), .rstN(rstN), .wrEn(wrEn), .wrHigh(wrHigh),
    .wrData(wrData), .testFaults(testFaults), .resetPulse(resetPulse),
    .selfTestPulse(selfTestPulse), .setPtrPulse(setPtrPulse),
    .dumpPulse(dumpPulse), .ptrAddr(ptrAddr), .busy(busy),
    .resultValid(resultValid), .resultData(resultData)
  );

  always #10 clk = ~clk;
  always begin
    #(txHalf);
    txClk = ~txClk;
  end
  always @(posedge txClk) txEdges++;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] statWord(input logic [3:0] f);
    logic [31:0] s = '0;
    s[12] = (f != 0);
    s[5]  = f[3];
    s[4]  = f[2];
    s[3]  = f[1];
    s[2]  = f[0];
    return s;
  endfunction

  // behavioural reference model
  logic [15:0] mLow = '0;
  bit mLowV = 0, mPR = 0, mPS = 0, mPP = 0, mPD = 0, mValid = 0, mWait = 0;
  logic [31:0] mPtr = '0, mData = '0;
  logic [31:0] q[$];
  int waitCyc = 0, txStart = 0, lastWait = 0;

  always @(posedge clk) if (rstN) begin
    logic [31:0] w;
    mPR = 0; mPS = 0; mPP = 0; mPD = 0;
    if (!mValid && !mWait && wrEn) begin
      if (!wrHigh) begin
        mLow = wrData; mLowV = 1;
      end else if (mLowV) begin
        w = {wrData, mLow};
        mLowV = 0;
        case (mLow[3:0])
          4'd0: begin mPR = 1; mWait = 1; waitCyc = 0; txStart = txEdges; end
          4'd1: begin mPS = 1; q.push_back(SIG); q.push_back(statWord(testFaults)); end
          4'd2: begin mPP = 1; mPtr = {w[31:4], 4'b0}; end
          4'd3: begin mPD = 1; q.push_back(mPtr); q.push_back(w); end
          default: ;
        endcase
      end
    end
    if (q.size() > 0) begin mValid = 1; mData = q.pop_front(); end
    else begin mValid = 0; mData = '0; end
  end

  always @(negedge clk) if (rstN) begin
    check(resetPulse == mPR, "R2 resetPulse", 32'(resetPulse), 32'(mPR));
    check(selfTestPulse == mPS, "R2 selfTestPulse", 32'(selfTestPulse), 32'(mPS));
    check(setPtrPulse == mPP, "R2 setPtrPulse", 32'(setPtrPulse), 32'(mPP));
    check(dumpPulse == mPD, "R2 dumpPulse", 32'(dumpPulse), 32'(mPD));
    check(ptrAddr == mPtr, "R5 ptrAddr", ptrAddr, mPtr);
    check(resultValid == mValid, "R7 R8 resultValid", 32'(resultValid), 32'(mValid));
    check(resultData == mData, "R7 R8 resultData", resultData, mData);
    if (mWait) begin
      if (busy) begin
        waitCyc++;
        if (waitCyc > 120) begin
          check(0, "R6 hold-off too long", waitCyc, 120);
          mWait = 0;
        end
      end else begin
        check(waitCyc >= 5, "R6 system-clock hold", waitCyc, 5);
        check(txEdges - txStart >= 10, "R6 tx-clock hold", txEdges - txStart, 10);
        lastWait = waitCyc;
        mWait = 0;
      end
    end else begin
      check(busy == mValid, "R6 R8 busy", 32'(busy), 32'(mValid));
    end
  end

  task automatic wr(input bit hi, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1; wrHigh = hi; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #3_000_000;
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    idle(3);
    // R10 reset state
    check({resetPulse, selfTestPulse, setPtrPulse, dumpPulse, busy, resultValid} == 0,
          "R10 outputs in reset", 32'({resetPulse, selfTestPulse, setPtrPulse,
          dumpPulse, busy, resultValid}), 0);
    check(ptrAddr == 0 && resultData == 0, "R10 data in reset", ptrAddr | resultData, 0);
    rstN = 1;
    idle(2);

    // R1 R5 assembly and set-pointer
    wr(0, 16'h5672); wr(1, 16'h1234); idle(2);
    check(ptrAddr == 32'h1234_5670, "R1 R5 assembled pointer", ptrAddr, 32'h1234_5670);

    // R3 orphan upper write
    wr(1, 16'hABCD); wr(1, 16'h0002); idle(2);
    check(ptrAddr == 32'h1234_5670, "R3 orphan upper ignored", ptrAddr, 32'h1234_5670);

    // R4 overwrite of pending lower half
    wr(0, 16'h0003); wr(0, 16'h9992); wr(1, 16'h0001); idle(2);
    check(ptrAddr == 32'h0001_9990, "R4 lower half replaced", ptrAddr, 32'h0001_9990);

    // R7 self-test, no faults then mixed faults
    testFaults = 4'b0000; wr(0, 16'h0001); wr(1, 16'h0000); idle(4);
    testFaults = 4'b1010; wr(0, 16'hFFF1); wr(1, 16'h0000); idle(4);
    testFaults = 4'b0101; wr(0, 16'h0011); wr(1, 16'h0000); idle(4);
    testFaults = 4'b0000;

    // R8 dump
    wr(0, 16'h00A3); wr(1, 16'hBEEF); idle(4);

    // R9 unused code, then lone upper must be ignored
    wr(0, 16'h4447); wr(1, 16'h5555); idle(2);
    wr(1, 16'h6666); idle(2);
    check(ptrAddr == 32'h0001_9990, "R9 unused code no effect", ptrAddr, 32'h0001_9990);

    // R6 reset with fast tx clock, writes during hold ignored
    txHalf = 3;
    wr(0, 16'h0000); wr(1, 16'h0000);
    wr(0, 16'h0042); wr(1, 16'h7777);
    while (mWait) @(negedge clk);
    wr(1, 16'h1111); idle(2);
    check(ptrAddr == 32'h0001_9990, "R6 writes during hold ignored", ptrAddr, 32'h0001_9990);

    // R6 reset with slow tx clock
    txHalf = 40;
    wr(0, 16'h0010); wr(1, 16'h0000);
    while (mWait) @(negedge clk);
    check(lastWait >= 40, "R6 slow tx dominates", lastWait, 40);
    txHalf = 3;
    wr(0, 16'h0000); wr(1, 16'h0000);
    while (mWait) @(negedge clk);
    check(lastWait >= 5 && lastWait < 40, "R6 fast tx hold length", lastWait, 5);

    // post-reset command still works (R2 R5)
    wr(0, 16'hCDE2); wr(1, 16'h89AB); idle(2);
    check(ptrAddr == 32'h89AB_CDE0, "R5 pointer after reset", ptrAddr, 32'h89AB_CDE0);
    idle(3);
    finishRun();
  end
endmodule